// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Read Gating

This block is a bank of sixteen general-purpose I/O lines controlled through a 16-bit register bus. Each line is an input or an output, set by a direction register. Output lines carry the value of a drive register. Input lines pass through a two-flop synchronizer. Each input line can raise an interrupt on either a rising or a falling edge. Each line has a sticky status bit, software clears status bits one at a time, and a mask register decides which pending bits reach the single interrupt output.

A pin-gate register sets which input lines software can see. A read of the input view returns the synchronized pin levels ANDed with the pin-gate register. The pin-gate register resets to all ones, so every line is visible until software hides one. The gate acts only on that read path. Edge capture still sees every input line.

Reads are combinational from the offset on the bus. Writes take effect on the rising clock edge where the write enable is high. The bus uses byte offsets, and registers sit on 4-byte steps.

Top module: `gpio_gate_bank`

## Requirements
- R1: After reset the registers hold these values: drive 0x0000, direction 0xFFFF, edge-select 0xFFFF, mask 0xFFFF, status 0x0000, pin-gate 0xFFFF. The interrupt output is low and no line is enabled as an output.
- R2: The offsets are 0x00 input view (read-only), 0x04 drive, 0x08 direction, 0x0C edge-select, 0x10 mask, 0x14 status and 0x18 pin-gate. A write to 0x04, 0x08, 0x0C, 0x10 or 0x18 reads back unchanged.
- R3: A read at 0x00 returns the synchronized inputs ANDed bitwise with pin-gate. A pin change becomes visible there after the second rising clock edge that follows it.
- R4: A direction bit of 1 makes its line an input and 0 makes it an output. pins_oe equals the inverse of direction, and pins_out equals drive AND NOT direction.
- R5: On an input line whose edge-select bit is 1, a rising pin transition sets that line's status bit at the third rising clock edge after the change, and not earlier.
- R6: On an input line whose edge-select bit is 0, a falling transition sets the status bit, and a rising transition does not.
- R7: Transitions on lines whose direction bit is 0 never set status.
- R8: A pin-gate bit of 0 hides the line from the 0x00 read only. Edge capture on that line still works.
- R9: Writing 1 to a status bit clears it, and bits written as 0 are unchanged. The interrupt output falls in the cycle after a write that clears the last unmasked pending bit. If an edge and a clear hit the same bit in the same cycle, the edge wins.
- R10: irq is the OR over status AND NOT mask. A mask bit of 1 keeps its pending bit from the interrupt, and clearing that mask bit raises irq right after the write.
- R11: An offset that is not listed reads as zero, and a write to it changes no register. Writes to 0x00 are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pins_in | input | 16 | Asynchronous pin levels |
| pins_out | output | 16 | Driven pin levels, zero on input lines |
| pins_oe | output | 16 | Output enable per line |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong synchronizer depth or a wrong previous-value register moves the cycle in which status appears, so the bench samples status both one cycle before and in the exact cycle it must set. A status bit that is captured wrongly or cleared wrongly shows at irq at once and in the 0x14 read the next cycle. A corrupt mask or pin-gate register shows in the very next read or irq sample. An undefined write that leaks into a register shows when every register is read back straight after it.

// File: rtl/gpio_gate_pkg.sv
// Package: register offsets and widths shared by the GPIO bank modules.
// Assumes byte offsets with one 16-bit register every 4 bytes.
package gpio_gate_pkg;
    localparam int unsigned OFS_W = 8;
    localparam logic [OFS_W-1:0] OFS_PIN_VIEW = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DRIVE    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_DIR      = 8'h08;
    localparam logic [OFS_W-1:0] OFS_EDGE_SEL = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK     = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STATUS   = 8'h14;
    localparam logic [OFS_W-1:0] OFS_GATE     = 8'h18;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer plus previous-value register for each line.
// Assumes pins are asynchronous. All stages reset to 0 together, so the
// first cycle after reset shows no edge.
module gpio_in_sync #(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pins_i,
    output logic [N_LINES-1:0] cur_o,
    output logic [N_LINES-1:0] prev_o
);
    logic [N_LINES-1:0] meta_q;

    // Shift pin levels through the metastability stages and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= pins_i;
            cur_o  <= meta_q;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/gpio_evt_status.sv
// Module: per-line edge detection, sticky status with write-one-to-clear,
// and the interrupt output. Assumes the direction bit is 1 for inputs and
// that edge-select is 1 for rising edges. An edge wins over a clear that
// hits the same bit in the same cycle.
module gpio_evt_status #(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] cur_i,
    input  logic [N_LINES-1:0] prev_i,
    input  logic [N_LINES-1:0] dir_i,
    input  logic [N_LINES-1:0] edge_sel_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic               clr_we_i,
    input  logic [N_LINES-1:0] clr_bits_i,
    output logic [N_LINES-1:0] status_o,
    output logic               irq_o
);
    logic [N_LINES-1:0] evt;

    // One edge detector per line; the polarity comes from edge-select.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_comb begin
            evt[i] = dir_i[i] & (edge_sel_i[i] ? (cur_i[i] & ~prev_i[i])
                                               : (~cur_i[i] & prev_i[i]));
        end
    end

    // Status update: clear the bits written as 1, then set the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= (status_o & ~({N_LINES{clr_we_i}} & clr_bits_i)) | evt;
        end
    end

    // Interrupt request from the unmasked pending bits.
    always_comb irq_o = |(status_o & ~mask_i);

    // R7: a bit that newly sets must belong to a line that was an input.
    assert_output_line_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(dir_i)) == '0));

    // R9: bits written as 1 with no edge in the same cycle read 0 next cycle.
    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((status_o & $past(clr_bits_i) & ~$past(evt)) == '0));

    // R10: the interrupt needs at least one pending bit.
    assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != '0));

    // R10: with every line masked the interrupt stays low.
    assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |-> !irq_o);
endmodule

// File: rtl/gpio_regfile.sv
// Module: register decode, storage and read multiplexer for the GPIO bank.
// Assumes combinational reads and writes on the rising edge. The status
// register is not stored here; a write to it becomes a clear request.
module gpio_regfile
    import gpio_gate_pkg::*;
#(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFS_W-1:0]   addr_i,
    input  logic               we_i,
    input  logic [N_LINES-1:0] wdata_i,
    input  logic [N_LINES-1:0] pin_view_i,
    input  logic [N_LINES-1:0] status_i,
    output logic [N_LINES-1:0] rdata_o,
    output logic [N_LINES-1:0] drive_o,
    output logic [N_LINES-1:0] dir_o,
    output logic [N_LINES-1:0] edge_sel_o,
    output logic [N_LINES-1:0] mask_o,
    output logic [N_LINES-1:0] gate_o,
    output logic               clr_we_o,
    output logic [N_LINES-1:0] clr_bits_o
);
    logic hit_known;

    // Decide whether the offset names a register at all.
    always_comb begin
        case (addr_i)
            OFS_PIN_VIEW, OFS_DRIVE, OFS_DIR, OFS_EDGE_SEL,
            OFS_MASK, OFS_STATUS, OFS_GATE: hit_known = 1'b1;
            default:                        hit_known = 1'b0;
        endcase
    end

    // Store the writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_o    <= '0;
            dir_o      <= '1;
            edge_sel_o <= '1;
            mask_o     <= '1;
            gate_o     <= '1;
        end else if (we_i) begin
            case (addr_i)
                OFS_DRIVE:    drive_o    <= wdata_i;
                OFS_DIR:      dir_o      <= wdata_i;
                OFS_EDGE_SEL: edge_sel_o <= wdata_i;
                OFS_MASK:     mask_o     <= wdata_i;
                OFS_GATE:     gate_o     <= wdata_i;
                default:      ;
            endcase
        end
    end

    // Pass a status write on as a clear request.
    always_comb begin
        clr_we_o   = we_i && (addr_i == OFS_STATUS);
        clr_bits_o = wdata_i;
    end

    // Read multiplexer; the input view is masked by the pin gate.
    always_comb begin
        case (addr_i)
            OFS_PIN_VIEW: rdata_o = pin_view_i & gate_o;
            OFS_DRIVE:    rdata_o = drive_o;
            OFS_DIR:      rdata_o = dir_o;
            OFS_EDGE_SEL: rdata_o = edge_sel_o;
            OFS_MASK:     rdata_o = mask_o;
            OFS_STATUS:   rdata_o = status_i;
            OFS_GATE:     rdata_o = gate_o;
            default:      rdata_o = '0;
        endcase
    end

    // R11: a write to an unknown offset or to the input view changes nothing.
    assert_undef_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (!hit_known || addr_i == OFS_PIN_VIEW))
        |=> $stable({drive_o, dir_o, edge_sel_o, mask_o, gate_o}));

    // R3: the input view never shows a line that the gate hides.
    assert_view_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == OFS_PIN_VIEW) |-> ((rdata_o & ~gate_o) == '0));
endmodule

// File: rtl/gpio_gate_bank.sv
// Module: top of the 16-line GPIO bank with per-pin read gating.
// Assumes a single clock and synchronous active-low reset. Pins are sampled
// asynchronously through the synchronizer.
module gpio_gate_bank
    import gpio_gate_pkg::*;
#(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFS_W-1:0]   bus_addr,
    input  logic               bus_we,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] pins_in,
    output logic [N_LINES-1:0] pins_out,
    output logic [N_LINES-1:0] pins_oe,
    output logic               irq
);
    logic [N_LINES-1:0] cur, prev, status, drive, dir, edge_sel, mask, gate, clr_bits;
    logic               clr_we;

    gpio_in_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_in), .cur_o(cur), .prev_o(prev)
    );

    gpio_regfile #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .pin_view_i(cur), .status_i(status),
        .rdata_o(bus_rdata), .drive_o(drive), .dir_o(dir), .edge_sel_o(edge_sel),
        .mask_o(mask), .gate_o(gate), .clr_we_o(clr_we), .clr_bits_o(clr_bits)
    );

    gpio_evt_status #(.N_LINES(N_LINES)) u_evt (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev), .dir_i(dir),
        .edge_sel_i(edge_sel), .mask_i(mask), .clr_we_i(clr_we),
        .clr_bits_i(clr_bits), .status_o(status), .irq_o(irq)
    );

    // Pad drive: enable the output lines and show drive data only on them.
    always_comb begin
        pins_oe  = ~dir;
        pins_out = drive & ~dir;
    end

    // R4: an input line is never driven high.
    assert_out_only_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins_out & ~pins_oe) == '0));
endmodule

// File: tb/gpio_gate_bank_tb.sv
module gpio_gate_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pins_in = '0;
    logic [15:0] pins_out;
    logic [15:0] pins_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_gate_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
        .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negative edge; reads combinationally.
    task automatic check_reg(input string tag, input logic [7:0] a, input logic [15:0] exp);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    // Starts and ends at a negative edge; the write commits on the posedge between.
    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic settle_pins(input logic [15:0] v);
        pins_in = v;
        repeat (4) @(negedge clk);
        bus_wr(8'h14, 16'hFFFF);
    endtask

    task automatic t_reset;
        check_reg("R1 drive", 8'h04, 16'h0000);
        check_reg("R1 dir", 8'h08, 16'hFFFF);
        check_reg("R1 edge", 8'h0C, 16'hFFFF);
        check_reg("R1 mask", 8'h10, 16'hFFFF);
        check_reg("R1 status", 8'h14, 16'h0000);
        check_reg("R1 gate", 8'h18, 16'hFFFF);
        check("R1 irq", {15'd0, irq}, 16'h0000);
        check("R1 oe", pins_oe, 16'h0000);
    endtask

    task automatic t_gate_view;
        pins_in = 16'hA5A5;
        @(negedge clk);
        check_reg("R3 view after one edge", 8'h00, 16'h0000);
        @(negedge clk);
        check_reg("R3 view after two edges", 8'h00, 16'hA5A5);
        bus_wr(8'h18, 16'h0F0F);
        check_reg("R2 gate readback", 8'h18, 16'h0F0F);
        check_reg("R3 gated view", 8'h00, 16'h0505);
        bus_wr(8'h18, 16'hFFFF);
        settle_pins(16'h0000);
        check_reg("R9 status cleared", 8'h14, 16'h0000);
    endtask

    task automatic t_outputs;
        bus_wr(8'h08, 16'hFF00);
        bus_wr(8'h04, 16'h1234);
        check_reg("R2 dir readback", 8'h08, 16'hFF00);
        check_reg("R2 drive readback", 8'h04, 16'h1234);
        check("R4 oe", pins_oe, 16'h00FF);
        check("R4 out", pins_out, 16'h0034);
        bus_wr(8'h08, 16'hFFFF);
        check("R4 out all inputs", pins_out, 16'h0000);
    endtask

    task automatic t_rise;
        bus_wr(8'h10, 16'hFFFE);
        pins_in = 16'h0001;
        repeat (2) @(negedge clk);
        check_reg("R5 status not yet", 8'h14, 16'h0000);
        check("R5 irq not yet", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        check_reg("R5 status set", 8'h14, 16'h0001);
        check("R10 irq raised", {15'd0, irq}, 16'h0001);
    endtask

    task automatic t_clear;
        bus_wr(8'h14, 16'h0002);
        check_reg("R9 zero bits untouched", 8'h14, 16'h0001);
        check("R9 irq still high", {15'd0, irq}, 16'h0001);
        bus_wr(8'h14, 16'h0001);
        check_reg("R9 bit cleared", 8'h14, 16'h0000);
        check("R9 irq dropped", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_fall;
        bus_wr(8'h0C, 16'hFFFD);
        bus_wr(8'h10, 16'hFFFD);
        pins_in = 16'h0003;
        repeat (4) @(negedge clk);
        check_reg("R6 rising ignored", 8'h14, 16'h0000);
        pins_in = 16'h0001;
        repeat (3) @(negedge clk);
        check_reg("R6 falling captured", 8'h14, 16'h0002);
        check("R6 irq", {15'd0, irq}, 16'h0001);
        bus_wr(8'h0C, 16'hFFFF);
        settle_pins(16'h0000);
    endtask

    task automatic t_mask;
        bus_wr(8'h10, 16'hFFFF);
        pins_in = 16'h0004;
        repeat (3) @(negedge clk);
        check_reg("R10 pending while masked", 8'h14, 16'h0004);
        check("R10 masked irq low", {15'd0, irq}, 16'h0000);
        bus_wr(8'h10, 16'hFFFB);
        check("R10 unmask raises irq", {15'd0, irq}, 16'h0001);
        bus_wr(8'h10, 16'hFFFF);
        settle_pins(16'h0000);
    endtask

    task automatic t_output_line;
        bus_wr(8'h08, 16'hFFF7);
        pins_in = 16'h0008;
        repeat (4) @(negedge clk);
        check_reg("R7 output line no capture", 8'h14, 16'h0000);
        bus_wr(8'h08, 16'hFFFF);
        settle_pins(16'h0000);
    endtask

    task automatic t_gate_edge;
        bus_wr(8'h18, 16'hFFEF);
        pins_in = 16'h0010;
        repeat (4) @(negedge clk);
        check_reg("R8 hidden line captured", 8'h14, 16'h0010);
        check_reg("R8 hidden line in view", 8'h00, 16'h0000);
        bus_wr(8'h18, 16'hFFFF);
        check_reg("R8 line visible again", 8'h00, 16'h0010);
        settle_pins(16'h0000);
    endtask

    task automatic t_undefined;
        bus_wr(8'h1C, 16'hBEEF);
        bus_wr(8'h00, 16'h0000);
        bus_wr(8'h02, 16'h0000);
        check_reg("R11 undefined reads zero", 8'h1C, 16'h0000);
        check_reg("R11 drive kept", 8'h04, 16'h1234);
        check_reg("R11 dir kept", 8'h08, 16'hFFFF);
        check_reg("R11 edge kept", 8'h0C, 16'hFFFF);
        check_reg("R11 mask kept", 8'h10, 16'hFFFF);
        check_reg("R11 gate kept", 8'h18, 16'hFFFF);
        check_reg("R11 status kept", 8'h14, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_view();
        t_outputs();
        t_rise();
        t_clear();
        t_fall();
        t_mask();
        t_output_line();
        t_gate_edge();
        t_undefined();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule